// File: doc/BRIEF.md
# Floating-Point Operand Boxing Unit

This combinational unit sits between a 64-bit floating-point register file and the execution datapath of a core that handles both single and double precision. On the read side it prepares up to three source operands per cycle, enough for a fused multiply-add. A 32-bit value is kept in the low half of a 64-bit register, and a correctly stored one has every upper bit set. Arithmetic-class operations require that pattern: an operand whose upper half is not all ones is replaced by the single-precision canonical NaN. Transfer-class operations (stores and register moves to the integer side) take the low half as it is and do not check the upper half.

On the write side the unit takes a result and produces the value to write back. A single-precision result gets its upper half forced to ones. A double-precision result is written unchanged. Each operand also carries a substitution flag that shows when the canonical NaN was used. The flag is for observation only and raises no exception. In double precision every operand passes through bit for bit, so NaN payloads are kept.

Top module: `fpbox_unit`

## Requirements
- R1: In single precision (`prec_dbl_i`=0) with the compute class (`op_xfer_i`=0), an operand whose bits 63:32 are all ones is output as `{32'h0, bits 31:0}` and its substitution flag is 0.
- R2: In single precision with the compute class, an operand whose bits 63:32 are not all ones (even one bit clear) is output as `64'h0000_0000_7FC0_0000` and its substitution flag is 1.
- R3: In single precision with the transfer class (`op_xfer_i`=1), each operand is output as `{32'h0, bits 31:0}` whatever bits 63:32 hold, and its flag is 0.
- R4: In double precision (`prec_dbl_i`=1) each operand is output unchanged for either class, including NaNs with non-canonical payloads, and its flag is 0.
- R5: With `wb_dbl_i`=0 the writeback output is `{32'hFFFF_FFFF, res_i[31:0]}`, so the upper bits of `res_i` are ignored.
- R6: With `wb_dbl_i`=1 the writeback output equals `res_i` unchanged.
- R7: A single-precision writeback, read as a 64-bit value, decodes as a negative quiet NaN: bit 63 is 1, bits 62:52 are all ones and bit 51 is 1.
- R8: Operand k (k = 0..2) is read from bits 64k+63:64k of `rs_data_i`, is driven on bits 64k+63:64k of `opnd_o` and uses flag bit k. Each operand is handled independently of the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs_data_i | input | 192 | Register read data for three source operands, operand k in bits 64k+63:64k |
| op_xfer_i | input | 1 | Operation class: 0 = compute, 1 = transfer |
| prec_dbl_i | input | 1 | Operand precision: 0 = single, 1 = double |
| opnd_o | output | 192 | Prepared operands, same lane layout as `rs_data_i` |
| subst_o | output | 3 | Per-operand flag, 1 when the canonical NaN was substituted |
| res_i | input | 64 | Result from the execution datapath |
| wb_dbl_i | input | 1 | Result precision: 0 = single, 1 = double |
| wb_data_o | output | 64 | Value for register writeback |

## Verification
Directed patterns check single-precision operands against upper halves that are all ones, all zeros and all ones except a single bit. This separates a full all-ones test from a test on only the top or bottom bit. The same badly stored operands are then sent with the transfer class, which must pass their low bits through. Double-precision operands with NaN payloads are sent with both classes, and the three operand lanes receive different patterns in the same cycle to catch swapped or shared lanes. A pseudo-random stream then mixes classes, precisions and upper-half patterns, and a behavioural model checks every operand, flag and writeback value on every clock.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;

    localparam int FLEN = 64;
    localparam int SLEN = 32;
    localparam int PAD  = FLEN - SLEN;

    localparam logic [SLEN-1:0] SNGL_QNAN = 32'h7FC0_0000;

    typedef enum logic {
        OPC_COMPUTE  = 1'b0,
        OPC_TRANSFER = 1'b1
    } op_class_e;

    typedef enum logic {
        PREC_SINGLE = 1'b0,
        PREC_DOUBLE = 1'b1
    } prec_e;

    typedef logic [FLEN-1:0] freg_t;

    typedef struct packed {
        freg_t val;
        logic  subst;
    } opnd_t;

    function automatic logic upper_all_ones(freg_t r);
        return &r[FLEN-1:SLEN];
    endfunction

    function automatic freg_t box_single(logic [SLEN-1:0] v);
        return {{PAD{1'b1}}, v};
    endfunction

    function automatic freg_t zext_single(logic [SLEN-1:0] v);
        return {{PAD{1'b0}}, v};
    endfunction

endpackage

// File: rtl/fpbox_unbox.sv
module fpbox_unbox
    import fpbox_pkg::*;
(
    input  freg_t     reg_i,
    input  op_class_e cls_i,
    input  prec_e     prec_i,
    output opnd_t     opnd_o
);

    logic            well_boxed;
    logic [SLEN-1:0] low_half;

    assign well_boxed = upper_all_ones(reg_i);
    assign low_half   = reg_i[SLEN-1:0];

    always_comb begin
        opnd_o.val   = reg_i;
        opnd_o.subst = 1'b0;
        if (prec_i == PREC_SINGLE) begin
            if (cls_i == OPC_TRANSFER) begin
                opnd_o.val = zext_single(low_half);
            end else if (well_boxed) begin
                opnd_o.val = zext_single(low_half);
            end else begin
                opnd_o.val   = zext_single(SNGL_QNAN);
                opnd_o.subst = 1'b1;
            end
        end
    end

    always_comb begin
        if (opnd_o.subst)
            assert_subst_is_qnan_R2: assert (opnd_o.val == 64'h0000_0000_7FC0_0000)
                else $error("substituted operand is not the canonical NaN");
        if (prec_i == PREC_DOUBLE)
            assert_double_passthru_R4: assert (opnd_o.val == reg_i && !opnd_o.subst)
                else $error("double operand altered");
        if (prec_i == PREC_SINGLE && cls_i == OPC_TRANSFER)
            assert_xfer_no_check_R3: assert (!opnd_o.subst && opnd_o.val[SLEN-1:0] == reg_i[SLEN-1:0])
                else $error("transfer operand checked or altered");
        if (prec_i == PREC_SINGLE && cls_i == OPC_COMPUTE && !opnd_o.subst)
            assert_kept_only_if_boxed_R1: assert (reg_i[FLEN-1:SLEN] == '1)
                else $error("badly boxed operand used without substitution");
    end

endmodule

// File: rtl/fpbox_box.sv
module fpbox_box
    import fpbox_pkg::*;
(
    input  freg_t res_i,
    input  prec_e prec_i,
    output freg_t wb_o
);

    always_comb begin
        if (prec_i == PREC_SINGLE)
            wb_o = box_single(res_i[SLEN-1:0]);
        else
            wb_o = res_i;
    end

    always_comb begin
        if (prec_i == PREC_SINGLE) begin
            assert_wb_upper_ones_R5: assert (wb_o[FLEN-1:SLEN] == '1 && wb_o[SLEN-1:0] == res_i[SLEN-1:0])
                else $error("single writeback not boxed");
            assert_wb_neg_qnan_R7: assert (wb_o[63] && (&wb_o[62:52]) && wb_o[51])
                else $error("boxed value is not a negative quiet NaN");
        end else begin
            assert_wb_double_R6: assert (wb_o == res_i)
                else $error("double writeback altered");
        end
    end

endmodule

// File: rtl/fpbox_unit.sv
module fpbox_unit
    import fpbox_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic [NSRC*FLEN-1:0] rs_data_i,
    input  logic                 op_xfer_i,
    input  logic                 prec_dbl_i,
    output logic [NSRC*FLEN-1:0] opnd_o,
    output logic [NSRC-1:0]      subst_o,
    input  logic [FLEN-1:0]      res_i,
    input  logic                 wb_dbl_i,
    output logic [FLEN-1:0]      wb_data_o
);

    op_class_e cls;
    prec_e     rd_prec;
    prec_e     wr_prec;

    assign cls     = op_class_e'(op_xfer_i);
    assign rd_prec = prec_e'(prec_dbl_i);
    assign wr_prec = prec_e'(wb_dbl_i);

    opnd_t lane_out [NSRC];

    for (genvar k = 0; k < NSRC; k++) begin : g_lane
        fpbox_unbox u_unbox (
            .reg_i  (rs_data_i[k*FLEN +: FLEN]),
            .cls_i  (cls),
            .prec_i (rd_prec),
            .opnd_o (lane_out[k])
        );
        assign opnd_o[k*FLEN +: FLEN] = lane_out[k].val;
        assign subst_o[k]             = lane_out[k].subst;
    end

    fpbox_box u_box (
        .res_i  (res_i),
        .prec_i (wr_prec),
        .wb_o   (wb_data_o)
    );

    always_comb begin
        if (op_xfer_i || prec_dbl_i)
            assert_no_flag_outside_compute_R8: assert (subst_o == '0)
                else $error("substitution flagged outside single compute");
    end

endmodule

// File: tb/test_fpbox_unit.sv
module test_fpbox_unit;

    localparam int PERIOD = 10;
    localparam int NSRC   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(PERIOD/2) clk = ~clk;

    logic [NSRC*64-1:0] rs_data;
    logic               op_xfer, prec_dbl, wb_dbl;
    logic [63:0]        res;
    logic [NSRC*64-1:0] opnd;
    logic [NSRC-1:0]    subst;
    logic [63:0]        wb_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    fpbox_unit #(.NSRC(NSRC)) i_fpbox_unit (
        .rs_data_i  (rs_data),
        .op_xfer_i  (op_xfer),
        .prec_dbl_i (prec_dbl),
        .opnd_o     (opnd),
        .subst_o    (subst),
        .res_i      (res),
        .wb_dbl_i   (wb_dbl),
        .wb_data_o  (wb_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference, compared once per clock away from the edge
    task automatic compare();
        for (int k = 0; k < NSRC; k++) begin
            logic [63:0] src, ev;
            logic        ef;
            string       tag;
            src = rs_data[k*64 +: 64];
            if (prec_dbl) begin
                ev = src; ef = 1'b0; tag = "R4";
            end else if (op_xfer) begin
                ev = {32'h0, src[31:0]}; ef = 1'b0; tag = "R3";
            end else if (src[63:32] == 32'hFFFF_FFFF) begin
                ev = {32'h0, src[31:0]}; ef = 1'b0; tag = "R1";
            end else begin
                ev = 64'h7FC0_0000; ef = 1'b1; tag = "R2";
            end
            chk($sformatf("%s R8 lane%0d value", tag, k), opnd[k*64 +: 64], ev);
            chk($sformatf("%s R8 lane%0d flag", tag, k), {63'h0, subst[k]}, {63'h0, ef});
        end
        if (wb_dbl) begin
            chk("R6 writeback", wb_data, res);
        end else begin
            chk("R5 writeback", wb_data, {32'hFFFF_FFFF, res[31:0]});
            chk("R7 negative qNaN", {61'h0, wb_data[63], &wb_data[62:52], wb_data[51]}, 64'h7);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                         input logic xf, input logic pd, input logic [63:0] r, input logic wd);
        @(posedge clk);
        rs_data  = {c, b, a};
        op_xfer  = xf;
        prec_dbl = pd;
        res      = r;
        wb_dbl   = wd;
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] s;
        rs_data = '0; op_xfer = 0; prec_dbl = 0; res = '0; wb_dbl = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: all-zero inputs, single compute => every lane substituted (R2)
        chk("R2 reset lane0", opnd[63:0], 64'h7FC0_0000);
        chk("R2 reset flags", {61'h0, subst}, 64'h7);
        chk("R5 reset writeback", wb_data, 64'hFFFF_FFFF_0000_0000);

        // R1 good boxes / R2 zero upper / R2 one-bit-clear upper, lanes differ (R8)
        apply(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 64'hFFFF_FFFE_C000_0000,
              1'b0, 1'b0, 64'h1234_5678_3F80_0000, 1'b0);
        apply(64'h7FFF_FFFF_1111_1111, 64'hFFFF_FFFF_7FC0_0000, 64'hFFFF_FFFF_FFFF_FFFF,
              1'b0, 1'b0, 64'h0, 1'b0);
        // R3 transfer ignores bad upper halves
        apply(64'h0000_0000_4000_0000, 64'hFFFF_FFFE_C000_0000, 64'h8000_0000_0000_0001,
              1'b1, 1'b0, 64'hDEAD_BEEF_0000_0000, 1'b0);
        // R4 double NaN payloads, both classes; R6 double writeback
        apply(64'h7FF0_0000_0000_0001, 64'hFFF8_DEAD_BEEF_0001, 64'h0000_0000_4000_0000,
              1'b0, 1'b1, 64'h7FF4_0000_0000_1234, 1'b1);
        apply(64'h7FF0_0000_0000_0001, 64'hFFFF_FFFE_C000_0000, 64'h3FF0_0000_0000_0000,
              1'b1, 1'b1, 64'h0000_0000_0000_0000, 1'b1);

        // pseudo-random mix
        s = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] v [3];
            for (int k = 0; k < 3; k++) begin
                s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
                v[k] = s;
                if (s[1:0] == 2'd0) v[k][63:32] = 32'hFFFF_FFFF;
                else if (s[1:0] == 2'd1) v[k][63:32] = 32'hFFFF_FFFF ^ (32'h1 << s[8:4]);
            end
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            apply(v[0], v[1], v[2], s[2], s[3], s ^ 64'h5555_AAAA_0F0F_F0F0, s[4]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule